// File: doc/BRIEF.md
# Iterative Word Shifter

This block shifts a data word left logically, right logically or right arithmetically by an amount taken from a start request. To keep area low it works over several clock cycles. One parameter picks the datapath. Unit mode moves the word one bit per cycle. Two-stage mode moves it four bits per cycle while four or more positions remain, then one bit per cycle. Barrel mode does the whole shift in one logarithmic network when the request is loaded. The block takes one request at a time. It shows `busy_o` from acceptance until completion and pulses `done_o` for one cycle while `result_o` holds the shifted word.

The controller is a three-state machine:
- **IDLE**: waits for `start_i`.
- **STEP**: applies one step per cycle and counts the remaining amount down.
- **DONE**: presents the result for one cycle.

The transitions are:
- **accept-to-step**: IDLE to STEP, on a request with a nonzero amount in a stepping mode.
- **accept-to-done**: IDLE to DONE, on a zero amount or in barrel mode.
- **last-step**: STEP to DONE, when the count reaches zero.
- **keep-stepping**: STEP to STEP, while a count remains.
- **release**: DONE to IDLE, always.

Top module: `step_shifter`

## Requirements
- R1: During reset and after it, `busy_o` and `done_o` are low and `result_o` is zero.
- R2: `op_i` = 2'b00 shifts left and fills with zeros; code 2'b10 behaves the same as 2'b00.
- R3: `op_i` = 2'b01 shifts right and fills vacated high bits with zeros.
- R4: `op_i` = 2'b11 shifts right and fills vacated high bits with the operand's bit 31. The sign bit is kept at every intermediate step.
- R5: In two-stage mode (MODE=1), a request with amount n > 0 gives `done_o` 1 + n/4 + n%4 cycles after the accepting edge. Four-bit steps all come before one-bit steps.
- R6: In unit mode (MODE=0), a request with amount n > 0 gives `done_o` n + 1 cycles after the accepting edge.
- R7: In barrel mode (MODE=2), every request gives `done_o` one cycle after the accepting edge.
- R8: An amount of zero gives `done_o` one cycle after acceptance, in every mode, with `result_o` equal to the operand.
- R9: `done_o` is high for exactly one cycle per accepted request, and `busy_o` is high in that cycle.
- R10: `start_i` is ignored while `busy_o` is high. The result of the running request is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when `busy_o` is low |
| op_i | input | 2 | Operation code (see R2 to R4) |
| operand_i | input | 32 | Word to shift |
| amount_i | input | 5 | Shift distance |
| busy_o | output | 1 | High from acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Shifted word, valid while `done_o` is high |

## Verification
Some properties are checked on every cycle by assertions:
- `done_o` never lasts two cycles.
- The sign bit stays fixed during arithmetic stepping.
- A zero amount completes at once with the operand unchanged.
- The stepping state never holds a zero count.
- Four-bit steps never follow one-bit steps.
- The stored operation code stays unchanged while busy.

The bench's scenarios are needed for two things:
- Exact result values for each operation and amount, compared against a shift model.
- The per-mode latency formulas, with three instances running side by side, plus ignored mid-operation requests.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        OP_SLL = 2'b00,
        OP_SRL = 2'b01,
        OP_ALT = 2'b10,
        OP_SRA = 2'b11
    } shf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_STEP = 2'b01,
        ST_DONE = 2'b10
    } shf_state_e;

    localparam int MODE_UNIT   = 0;
    localparam int MODE_TWO    = 1;
    localparam int MODE_BARREL = 2;

    function automatic logic op_is_right(input shf_op_e op);
        return (op == OP_SRL) || (op == OP_SRA);
    endfunction

    function automatic logic op_is_arith(input shf_op_e op);
        return op == OP_SRA;
    endfunction

endpackage

// File: rtl/shf_stepper.sv
// Fixed-distance shift by DIST positions, direction and fill chosen at run time.
module shf_stepper #(
    parameter int W    = 32,
    parameter int DIST = 1
) (
    input  logic [W-1:0] din,
    input  logic         right,
    input  logic         arith,
    output logic [W-1:0] dout
);
    logic fill;

    assign fill = arith & din[W-1];

    always_comb begin
        if (right) begin
            dout = {{DIST{fill}}, din[W-1:DIST]};
        end else begin
            dout = {din[W-DIST-1:0], {DIST{1'b0}}};
        end
    end

    initial begin
        assert (DIST > 0 && DIST < W)
            else $error("shf_stepper: DIST out of range");
    end
endmodule

// File: rtl/shf_barrel.sv
// Logarithmic shifter: stage i moves by 2**i when amount bit i is set.
module shf_barrel #(
    parameter int W     = 32,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  logic             right,
    input  logic             arith,
    output logic [W-1:0]     dout
);
    logic [AMT_W:0][W-1:0] stage;

    assign stage[0] = din;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        logic [W-1:0] moved;

        shf_stepper #(
            .W    (W),
            .DIST (1 << i)
        ) u_step (
            .din   (stage[i]),
            .right (right),
            .arith (arith),
            .dout  (moved)
        );

        assign stage[i+1] = amt[i] ? moved : stage[i];
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/shf_ctrl.sv
// Sequencer: counts the remaining distance and selects the step size.
module shf_ctrl
    import shf_pkg::*;
#(
    parameter int AMT_W = 5,
    parameter int MODE  = MODE_TWO,
    parameter int BIG   = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [AMT_W-1:0] amount_i,
    output logic             accept_o,
    output logic             step_o,
    output logic             big_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [AMT_W-1:0] BIG_AMT = AMT_W'(BIG);
    localparam logic [AMT_W-1:0] ONE_AMT = AMT_W'(1);
    localparam bit               USE_BIG = (MODE == MODE_TWO);
    localparam bit               ONE_SHOT = (MODE == MODE_BARREL);

    shf_state_e       state_q, state_d;
    logic [AMT_W-1:0] cnt_q, cnt_d;
    logic             accept, big;

    // Next-state and count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        big     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept = 1'b1;
                    if (ONE_SHOT || amount_i == '0) begin
                        state_d = ST_DONE;     // accept-to-done
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_STEP;     // accept-to-step
                        cnt_d   = amount_i;
                    end
                end
            end
            ST_STEP: begin
                big   = USE_BIG && (cnt_q >= BIG_AMT);
                cnt_d = big ? (cnt_q - BIG_AMT) : (cnt_q - ONE_AMT);
                if (cnt_d == '0) begin
                    state_d = ST_DONE;         // last-step
                end                            // else keep-stepping
            end
            ST_DONE: begin
                state_d = ST_IDLE;             // release
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        accept_o = accept;
        big_o    = big;
        step_o   = (state_q == ST_STEP);
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
    end

    // R5: a stepping cycle always has distance left to cover
    assert_step_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STEP) |-> (cnt_q != '0));

    if (USE_BIG) begin : g_two_chk
        // R5: once a one-bit step is taken, no four-bit step follows
        assert_big_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (step_o && !big_o) |=> !big_o);
    end

    if (ONE_SHOT) begin : g_barrel_chk
        // R7: barrel mode finishes right after acceptance
        assert_barrel_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            accept_o |=> (state_q == ST_DONE));
    end
endmodule

// File: rtl/step_shifter.sv
module step_shifter
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MODE   = MODE_TWO,
    parameter int BIG    = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [1:0]                op_i,
    input  logic [DATA_W-1:0]         operand_i,
    input  logic [$clog2(DATA_W)-1:0] amount_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [DATA_W-1:0]         result_o
);
    localparam int AMT_W = $clog2(DATA_W);

    shf_op_e           op_in, op_q;
    logic [DATA_W-1:0] data_q, load_w, small_w, big_w;
    logic              accept, step, big;
    logic              right_q, arith_q;

    assign op_in   = shf_op_e'(op_i);
    assign right_q = op_is_right(op_q);
    assign arith_q = op_is_arith(op_q);

    shf_ctrl #(
        .AMT_W (AMT_W),
        .MODE  (MODE),
        .BIG   (BIG)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .amount_i (amount_i),
        .accept_o (accept),
        .step_o   (step),
        .big_o    (big),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    shf_stepper #(
        .W    (DATA_W),
        .DIST (1)
    ) u_small (
        .din   (data_q),
        .right (right_q),
        .arith (arith_q),
        .dout  (small_w)
    );

    if (MODE == MODE_TWO) begin : g_big
        shf_stepper #(
            .W    (DATA_W),
            .DIST (BIG)
        ) u_big (
            .din   (data_q),
            .right (right_q),
            .arith (arith_q),
            .dout  (big_w)
        );
    end else begin : g_no_big
        assign big_w = small_w;
    end

    if (MODE == MODE_BARREL) begin : g_barrel
        shf_barrel #(
            .W     (DATA_W),
            .AMT_W (AMT_W)
        ) u_barrel (
            .din   (operand_i),
            .amt   (amount_i),
            .right (op_is_right(op_in)),
            .arith (op_is_arith(op_in)),
            .dout  (load_w)
        );
    end else begin : g_no_barrel
        assign load_w = operand_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
            op_q   <= OP_SLL;
        end else if (accept) begin
            data_q <= load_w;
            op_q   <= op_in;
        end else if (step) begin
            data_q <= big ? big_w : small_w;
        end
    end

    assign result_o = data_q;

    // R9: completion is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: done only inside a busy window
    assert_done_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    // R4: arithmetic stepping never alters the sign bit
    assert_sra_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && op_q == OP_SRA) |=> (result_o[DATA_W-1] == $past(result_o[DATA_W-1])));

    // R8: zero distance completes next cycle with the operand untouched
    assert_zero_amt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && amount_i == '0) |=> (done_o && result_o == $past(operand_i)));

    // R10: a request arriving while busy does not replace the running operation
    assert_ignore_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> (op_q == $past(op_q)));
endmodule

// File: tb/test_step_shifter.sv
`timescale 1ns/1ps
module test_step_shifter;
    import shf_pkg::*;

    localparam int W  = 32;
    localparam int AW = 5;
    localparam int NI = 3;   // 0: two-stage, 1: unit, 2: barrel

    typedef struct {
        logic [W-1:0] exp;
        int           lat;
        int           acc;
        int           req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [W-1:0] operand = '0;
    logic [AW-1:0] amt = '0;
    logic [NI-1:0] busy_w, done_w;
    logic [W-1:0] res_w [NI];

    item_t sb_q [NI][$];
    bit    prev_done [NI];
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    step_shifter #(.DATA_W(W), .MODE(MODE_TWO)) i_step_shifter (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .operand_i(operand),
        .amount_i(amt), .busy_o(busy_w[0]), .done_o(done_w[0]), .result_o(res_w[0]));

    step_shifter #(.DATA_W(W), .MODE(MODE_UNIT)) i_step_shifter_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .operand_i(operand),
        .amount_i(amt), .busy_o(busy_w[1]), .done_o(done_w[1]), .result_o(res_w[1]));

    step_shifter #(.DATA_W(W), .MODE(MODE_BARREL)) i_step_shifter_barrel (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .operand_i(operand),
        .amount_i(amt), .busy_o(busy_w[2]), .done_o(done_w[2]), .result_o(res_w[2]));

    function automatic logic [W-1:0] model(input logic [1:0] o, input logic [W-1:0] v,
                                           input int n);
        case (o)
            2'b01:   return v >> n;
            2'b11:   return W'($signed(v) >>> n);
            default: return v << n;
        endcase
    endfunction

    function automatic int lat_of(input int k, input int n);
        if (n == 0 || k == 2) return 1;
        if (k == 0) return 1 + n / 4 + n % 4;
        return 1 + n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: waits for all instances idle, issues one request, optionally pokes start while busy
    task automatic apply(input logic [1:0] o, input logic [W-1:0] v, input int n,
                         input int req, input bit poke);
        while (busy_w != '0) @(negedge clk);
        op = o; operand = v; amt = AW'(n); start = 1'b1;
        for (int k = 0; k < NI; k++) begin
            sb_q[k].push_back('{exp: model(o, v, n), lat: lat_of(k, n), acc: cyc + 1, req: req});
        end
        @(negedge clk);
        if (poke) begin
            // R10: a second strobe with different data while every instance is busy
            op = ~o; operand = ~v; amt = AW'(n + 3);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    // Monitor: pops expected items as done pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NI; k++) begin
                if (done_w[k]) begin
                    check(!prev_done[k], "R9", $sformatf("done longer than one cycle inst %0d", k),
                          32'(prev_done[k]), 32'd0);
                    check(busy_w[k], "R9", $sformatf("busy low during done inst %0d", k),
                          32'(busy_w[k]), 32'd1);
                    if (sb_q[k].size() == 0) begin
                        check(1'b0, "R9", $sformatf("unexpected done inst %0d", k), 32'd1, 32'd0);
                    end else begin
                        item_t it;
                        it = sb_q[k].pop_front();
                        check(res_w[k] == it.exp, $sformatf("R%0d", it.req),
                              $sformatf("result inst %0d", k), res_w[k], it.exp);
                        check(cyc - it.acc + 1 == it.lat,
                              (k == 0) ? "R5" : (k == 1) ? "R6" : "R7",
                              $sformatf("latency inst %0d", k),
                              32'(cyc - it.acc + 1), 32'(it.lat));
                    end
                end
                prev_done[k] = done_w[k];
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        for (int k = 0; k < NI; k++) begin
            check(busy_w[k] == 1'b0 && done_w[k] == 1'b0, "R1", "flags in reset",
                  {30'd0, busy_w[k], done_w[k]}, 32'd0);
            check(res_w[k] == '0, "R1", "result in reset", res_w[k], '0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            check(busy_w[k] == 1'b0 && done_w[k] == 1'b0, "R1", "flags after reset",
                  {30'd0, busy_w[k], done_w[k]}, 32'd0);
        end

        // R2: left logical, and code 2'b10 as its alias
        apply(2'b00, 32'h8000_0001, 1, 2, 1'b0);
        apply(2'b00, 32'hDEAD_BEEF, 31, 2, 1'b0);
        apply(2'b10, 32'h1234_5678, 9, 2, 1'b0);
        // R3: right logical
        apply(2'b01, 32'hF000_000F, 4, 3, 1'b0);
        apply(2'b01, 32'h8000_0000, 31, 3, 1'b0);
        // R4: arithmetic right with sign fill
        apply(2'b11, 32'h8000_0000, 31, 4, 1'b0);
        apply(2'b11, 32'hF0F0_1234, 7, 4, 1'b0);
        apply(2'b11, 32'h7FFF_FFFF, 8, 4, 1'b0);
        // R5/R6 boundaries: just below, at and above a four-bit multiple
        apply(2'b01, 32'hCAFE_F00D, 3, 3, 1'b0);
        apply(2'b00, 32'hCAFE_F00D, 5, 2, 1'b0);
        apply(2'b11, 32'hCAFE_F00D, 28, 4, 1'b0);
        // R8: zero amount in every mode
        apply(2'b11, 32'h9876_5432, 0, 8, 1'b0);
        apply(2'b00, 32'h0000_0001, 0, 8, 1'b0);
        // R10: strobe while busy is ignored (zero, short and long amounts)
        apply(2'b01, 32'hA5A5_5A5A, 0, 10, 1'b1);
        apply(2'b11, 32'h8421_8421, 6, 10, 1'b1);
        apply(2'b00, 32'h0F0F_0F0F, 31, 10, 1'b1);
        // Mixed traffic
        for (int i = 0; i < 40; i++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 3));
            apply(o, $urandom, int'($urandom_range(0, 31)),
                  (o == 2'b01) ? 3 : (o == 2'b11) ? 4 : 2, 1'(i % 5 == 0));
        end

        while (busy_w != '0 || sb_q[0].size() != 0 || sb_q[1].size() != 0
               || sb_q[2].size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        // R9: no stray done after all work drained
        check(done_w == '0, "R9", "done idle at end", 32'(done_w), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule